// File: doc/BRIEF.md
# ECC Error Capture and Status Register

This block keeps the record of memory ECC failures for a single-channel SDRAM controller. The ECC checker raises a one-cycle event for a corrected (single-bit) or uncorrectable (multi-bit) read. Each event comes with the physical address and the 8-bit syndrome. The block freezes the first such failure in one 32-bit status register. It keeps that record until software acknowledges it by writing ones to both status flags in a single write.

The same register holds three control bits. One turns off the write-back of corrected data. One lets a logged multi-bit error raise the system-error line. One lets a logged single-bit error raise the NMI line. For every corrected read, the block issues a one-cycle scrub request carrying the failing address, unless scrubbing is turned off. Software accesses the register through a single-word port: the read value is always present, and a write strobe updates the writable bits.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous reset, the register reads 0, and `nmi_irq`, `serr_irq` and `scrub_req` are low.
- R2: While both flags are 0, a single-bit event sets bit 0 and a multi-bit event sets bit 1. The update is visible the cycle after the event, and only one of the two bits is ever 1.
- R3: If both event kinds arrive in the same cycle while the log is empty, bit 1 (multi-bit) is set and bit 0 stays 0.
- R4: On capture, bits 30:12 receive address bits 32:14 (a 16 KiB grain) and bits 11:4 receive the syndrome. These fields are read-only: writes leave them unchanged.
- R5: While either flag is set, further events of either kind do not change the flags, the address field or the syndrome field.
- R6: A write clears the flags only when write-data bits 1 and 0 are both 1. A write with only one of them set, or with neither set, leaves the flags unchanged.
- R7: An event that arrives in the same cycle as a clearing write is not logged. The flags read 0 afterwards.
- R8: Bit 31 (scrub disable), bit 3 (system-error enable) and bit 2 (NMI enable) take the write data on every write and read back what was written.
- R9: `nmi_irq` is high exactly while bit 0 and bit 2 are both 1.
- R10: `serr_irq` is high exactly while bit 1 and bit 3 are both 1.
- R11: When bit 31 is 0, each single-bit event produces `scrub_req` high for one cycle, in the following cycle, with `scrub_addr` equal to the event address. This happens even while the log is full.
- R12: When bit 31 is 1, single-bit events produce no `scrub_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_sbe | input | 1 | Corrected single-bit error event pulse |
| ev_mbe | input | 1 | Uncorrectable multi-bit error event pulse |
| ev_addr | input | 33 | Physical address of the failing read |
| ev_syn | input | 8 | ECC syndrome of the failing read |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| scrub_req | output | 1 | One-cycle request to write back corrected data |
| scrub_addr | output | 33 | Address for the scrub write |
| nmi_irq | output | 1 | Level NMI request for a logged single-bit error |
| serr_irq | output | 1 | Level system-error request for a logged multi-bit error |

## Verification
The assertions check, on every cycle, the rules that relate one cycle to the next. A full log keeps its address and syndrome stable. A partial acknowledge leaves the flags alone. A clearing write always empties the flags. Simultaneous events record the multi-bit class. The scrub pulse follows a corrected read exactly when scrubbing is enabled. Other behaviour only shows up through the bench's scenarios, because it depends on what software wrote earlier and on ordering across many cycles. That includes which error reaches the log first after an acknowledge, read-only fields surviving a write of all ones, and interrupt levels following the enables as software changes them.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int REG_W = 32;
    localparam int SYN_W = 8;
    localparam int TAG_W = 19;

    localparam int POS_SBE       = 0;
    localparam int POS_MBE       = 1;
    localparam int POS_NMI_EN    = 2;
    localparam int POS_SERR_EN   = 3;
    localparam int POS_SCRUB_DIS = 31;

    typedef struct packed {
        logic             mbe;
        logic             sbe;
        logic [TAG_W-1:0] tag;
        logic [SYN_W-1:0] syn;
    } log_t;

    typedef struct packed {
        logic scrub_dis;
        logic serr_en;
        logic nmi_en;
    } ctl_t;

    typedef struct packed {
        ctl_t       ctl;
        logic [1:0] w1c;
    } wreq_t;

    function automatic logic [REG_W-1:0] pack_reg(input log_t l, input ctl_t c);
        return {c.scrub_dis, l.tag, l.syn, c.serr_en, c.nmi_en, l.mbe, l.sbe};
    endfunction

    function automatic logic is_ack(input logic [1:0] w1c);
        return w1c[1] & w1c[0];
    endfunction

endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
    import ecc_log_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  wreq_t wreq,
    output ctl_t  ctl_q,
    output logic  ack
);

    assign ack = wr & is_ack(wreq.w1c);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q <= wreq.ctl;
        end
    end

    // R8
    ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl_q == $past(wreq.ctl)));

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_sbe,
    input  logic             ev_mbe,
    input  logic [TAG_W-1:0] ev_tag,
    input  logic [SYN_W-1:0] ev_syn,
    input  logic             ack,
    output log_t             log_q
);

    logic empty;
    logic take;

    assign empty = ~(log_q.sbe | log_q.mbe);
    assign take  = empty & (ev_sbe | ev_mbe) & ~ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            log_q <= '0;
        end else if (ack) begin
            log_q.sbe <= 1'b0;
            log_q.mbe <= 1'b0;
        end else if (take) begin
            log_q.mbe <= ev_mbe;
            log_q.sbe <= ~ev_mbe;
            log_q.tag <= ev_tag;
            log_q.syn <= ev_syn;
        end
    end

    // R5
    hold_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty && !ack) |=> ($stable(log_q.tag) && $stable(log_q.syn)
                              && $stable(log_q.sbe) && $stable(log_q.mbe)));

    // R3
    mbe_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && ev_sbe && ev_mbe && !ack) |=> (log_q.mbe && !log_q.sbe));

    // R7
    ack_empties_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> (!log_q.sbe && !log_q.mbe));

    // R2
    one_class_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && (ev_sbe || ev_mbe) && !ack) |=> $onehot({log_q.sbe, log_q.mbe}));

endmodule

// File: rtl/ecc_log_scrub.sv
module ecc_log_scrub #(
    parameter int ADDR_W = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_sbe,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              scrub_dis,
    output logic              scrub_req,
    output logic [ADDR_W-1:0] scrub_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            scrub_req  <= 1'b0;
            scrub_addr <= '0;
        end else begin
            scrub_req <= ev_sbe & ~scrub_dis;
            if (ev_sbe & ~scrub_dis) begin
                scrub_addr <= ev_addr;
            end
        end
    end

    // R11
    scrub_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_sbe && !scrub_dis) |=> (scrub_req && scrub_addr == $past(ev_addr)));

    // R12
    scrub_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        scrub_dis |=> !scrub_req);

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_sbe,
    input  logic              ev_mbe,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [SYN_W-1:0]  ev_syn,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              scrub_req,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic              nmi_irq,
    output logic              serr_irq
);

    localparam int TAG_LSB = ADDR_W - TAG_W;

    wreq_t wreq;
    ctl_t  ctl_q;
    log_t  log_q;
    logic  ack;
    logic  unused_wbits;

    assign wreq.ctl.scrub_dis = reg_wdata[POS_SCRUB_DIS];
    assign wreq.ctl.serr_en   = reg_wdata[POS_SERR_EN];
    assign wreq.ctl.nmi_en    = reg_wdata[POS_NMI_EN];
    assign wreq.w1c           = {reg_wdata[POS_MBE], reg_wdata[POS_SBE]};
    assign unused_wbits       = ^reg_wdata[POS_SCRUB_DIS-1:POS_SERR_EN+1];

    ecc_log_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wreq  (wreq),
        .ctl_q (ctl_q),
        .ack   (ack)
    );

    ecc_log_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .ev_sbe (ev_sbe),
        .ev_mbe (ev_mbe),
        .ev_tag (ev_addr[ADDR_W-1:TAG_LSB]),
        .ev_syn (ev_syn),
        .ack    (ack),
        .log_q  (log_q)
    );

    ecc_log_scrub #(.ADDR_W(ADDR_W)) u_scrub (
        .clk        (clk),
        .rst        (rst),
        .ev_sbe     (ev_sbe),
        .ev_addr    (ev_addr),
        .scrub_dis  (ctl_q.scrub_dis),
        .scrub_req  (scrub_req),
        .scrub_addr (scrub_addr)
    );

    assign reg_rdata = pack_reg(log_q, ctl_q);
    assign nmi_irq   = log_q.sbe & ctl_q.nmi_en;
    assign serr_irq  = log_q.mbe & ctl_q.serr_en;

    // R6
    partial_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ((reg_rdata[1] || reg_rdata[0]) && reg_wr && !(reg_wdata[1] && reg_wdata[0]))
        |=> (reg_rdata[1:0] == $past(reg_rdata[1:0])));

    // R10
    serr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (serr_irq && ack) |=> !serr_irq);

endmodule

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 33;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_sbe = 1'b0, ev_mbe = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [7:0]    ev_syn = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          scrub_req, nmi_irq, serr_irq;
    logic [AW-1:0] scrub_addr;

    int n_tests = 0;
    int n_fail = 0;
    bit running = 1'b0;

    ecc_err_log u_ecc_err_log (
        .clk(clk), .rst(rst), .ev_sbe(ev_sbe), .ev_mbe(ev_mbe),
        .ev_addr(ev_addr), .ev_syn(ev_syn), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scrub_req(scrub_req), .scrub_addr(scrub_addr),
        .nmi_irq(nmi_irq), .serr_irq(serr_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    bit            m_sbe, m_mbe, m_dis, m_serr, m_nmi, m_scrub;
    bit [18:0]     m_tag;
    bit [7:0]      m_syn;
    bit [AW-1:0]   m_saddr;

    always @(posedge clk) begin
        if (rst) begin
            m_sbe = 0; m_mbe = 0; m_dis = 0; m_serr = 0; m_nmi = 0;
            m_scrub = 0; m_tag = 0; m_syn = 0; m_saddr = 0;
        end else begin
            bit was_empty, clearing;
            was_empty = !(m_sbe || m_mbe);
            clearing  = reg_wr && reg_wdata[0] && reg_wdata[1];
            m_scrub = ev_sbe && !m_dis;
            if (m_scrub) m_saddr = ev_addr;
            if (clearing) begin
                m_sbe = 0; m_mbe = 0;
            end else if (was_empty && (ev_sbe || ev_mbe)) begin
                if (ev_mbe) m_mbe = 1; else m_sbe = 1;
                m_tag = ev_addr[AW-1:14];
                m_syn = ev_syn;
            end
            if (reg_wr) begin
                m_dis = reg_wdata[31]; m_serr = reg_wdata[3]; m_nmi = reg_wdata[2];
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            chk("R2 R3 R5 R6 R7 flags", 64'(reg_rdata[1:0]), 64'({m_mbe, m_sbe}));
            chk("R4 R5 address field", 64'(reg_rdata[30:12]), 64'(m_tag));
            chk("R4 syndrome field", 64'(reg_rdata[11:4]), 64'(m_syn));
            chk("R8 control bits", 64'({reg_rdata[31], reg_rdata[3], reg_rdata[2]}),
                64'({m_dis, m_serr, m_nmi}));
            chk("R9 nmi level", 64'(nmi_irq), 64'(m_sbe && m_nmi));
            chk("R10 serr level", 64'(serr_irq), 64'(m_mbe && m_serr));
            chk("R11 R12 scrub pulse", 64'(scrub_req), 64'(m_scrub));
            if (m_scrub) chk("R11 scrub address", 64'(scrub_addr), 64'(m_saddr));
        end
    end

    task automatic step(input bit s, input bit m, input logic [AW-1:0] a,
                        input logic [7:0] y, input bit w, input logic [31:0] d);
        ev_sbe = s; ev_mbe = m; ev_addr = a; ev_syn = y; reg_wr = w; reg_wdata = d;
        @(negedge clk);
        ev_sbe = 0; ev_mbe = 0; reg_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 register after reset", 64'(reg_rdata), 64'h0);
        chk("R1 outputs after reset", 64'({nmi_irq, serr_irq, scrub_req}), 64'h0);
        running = 1'b1;

        // R2 single-bit capture with scrub (R11)
        step(1, 0, 33'h1_2345_6789, 8'h5A, 0, 0);
        idle(2);
        // R5 later events ignored while full; R11 scrub still issued
        step(0, 1, 33'h0_FFFF_C000, 8'hC3, 0, 0);
        step(1, 0, 33'h0_0000_4000, 8'h11, 0, 0);
        idle(1);
        // R6 partial acknowledge writes
        step(0, 0, 0, 0, 1, 32'h0000_0001);
        step(0, 0, 0, 0, 1, 32'h0000_0002);
        step(0, 0, 0, 0, 1, 32'h0000_0000);
        // R7 acknowledge with coincident event
        step(0, 1, 33'h1_0000_0000, 8'h77, 1, 32'h0000_0003);
        idle(1);
        // R8 enables, scrub disabled; R10 multi-bit raises serr; R12 no scrub
        step(0, 0, 0, 0, 1, 32'h8000_000C);
        step(0, 1, 33'h1_AAAA_8000, 8'hE1, 0, 0);
        step(1, 0, 33'h0_1234_0000, 8'h02, 0, 0);
        idle(2);
        // R10 acknowledge drops serr; R3 simultaneous events
        step(0, 0, 0, 0, 1, 32'h8000_000F);
        step(1, 1, 33'h0_5555_4000, 8'h3C, 0, 0);
        idle(1);
        // R4 read-only fields survive write of ones; R9 nmi
        step(0, 0, 0, 0, 1, 32'h7FFF_FFF7);
        step(1, 0, 33'h1_0F0F_C000, 8'h99, 0, 0);
        step(0, 0, 0, 0, 1, 32'h7FFF_FFF4);
        idle(2);
        step(0, 0, 0, 0, 1, 32'h0000_0003);

        for (int i = 0; i < 400; i++) begin
            bit s, m, w;
            logic [31:0] d;
            s = ($urandom_range(0, 3) == 0);
            m = ($urandom_range(0, 5) == 0);
            w = ($urandom_range(0, 6) == 0);
            d = $urandom;
            step(s, m, {$urandom_range(0, 1), 32'($urandom)}, 8'($urandom), w, d);
        end
        idle(2);
        finish_run();
    end
endmodule